// File: doc/BRIEF.md
# Parity-Interleaving Chunk Copy Engine

This block copies blocks of data between two memories over a 64-bit data path. One side, the DRAM side, stores each 128-byte data chunk with a 4-byte check word right after it, so one chunk takes 132 bytes there. The other side, the SRAM side, holds plain data packed at 128 bytes per chunk. The copy can run in any of the four source/destination combinations. When the source is on the DRAM side, the engine rebuilds the check word from the data it reads and compares it with the stored one. When the destination is on the DRAM side, the engine writes a freshly computed check word after each chunk and never copies the stored one.

Software gives a source byte address, a destination byte address, a chunk count and two side-select bits, and pulses `start`. The engine reads and writes one 8-byte beat at a time. Each memory port is single-ported with one cycle of read latency, and a beat takes two cycles. The engine reports completion with a one-cycle `done` pulse. A check-word mismatch raises a sticky `parity_err` flag but does not stop the copy.

Top module: `mcopy_engine`

## Requirements
- R1: On the DRAM side, chunk k sits at base + 132*k. Its check word is at chunk offset 128. On the SRAM side, chunk k sits at base + 128*k.
- R2: `src_is_dram` and `dst_is_dram` select the source and destination sides independently (1 = DRAM side, 0 = SRAM side). All four combinations work.
- R3: Data moves as sixteen 8-byte beats per chunk at offsets 0, 8, ..., 120, in ascending order. Byte i of a beat is bits [8i+7:8i] (little-endian). Each beat's read comes one cycle before its write.
- R4: Check-word byte j (bits [8j+7:8j], stored at chunk offset 128+j) is the XOR of all data bytes whose chunk offset modulo 4 equals j. A DRAM destination receives this value, computed from the copied data, as one 4-byte write with `dram_par` = 1 on `dram_wdata[31:0]`. A stored source check word is never reused.
- R5: A DRAM-side source chunk whose stored check word differs from the computed one sets `parity_err`. The copy still completes. The flag stays set until the next accepted start clears it.
- R6: A chunk count of zero produces `done` in the cycle after the start is accepted, with no memory access.
- R7: `done` is high for exactly one cycle, after the last write of the transfer. `busy` is high from the cycle after acceptance through the `done` cycle.
- R8: A `start` while `busy` is high is ignored. The transfer in progress keeps its parameters and its write sequence.
- R9: Writes go only to the destination side, and reads only to the source side. Neither port is requested while the engine is idle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| start | input | 1 | Start request, sampled when idle |
| src_is_dram | input | 1 | Source side select (1 = DRAM side) |
| dst_is_dram | input | 1 | Destination side select (1 = DRAM side) |
| src_addr | input | 16 | Source base byte address |
| dst_addr | input | 16 | Destination base byte address |
| num_chunks | input | 8 | Number of 128-byte chunks |
| busy | output | 1 | Transfer in progress |
| done | output | 1 | One-cycle completion pulse |
| parity_err | output | 1 | Sticky check-word mismatch flag |
| dram_req | output | 1 | DRAM-side access request |
| dram_we | output | 1 | DRAM-side write enable |
| dram_par | output | 1 | DRAM-side access is the 4-byte check word |
| dram_addr | output | 16 | DRAM-side byte address |
| dram_wdata | output | 64 | DRAM-side write data |
| dram_rdata | input | 64 | DRAM-side read data, one cycle after a read |
| sram_req | output | 1 | SRAM-side access request |
| sram_we | output | 1 | SRAM-side write enable |
| sram_addr | output | 16 | SRAM-side byte address |
| sram_wdata | output | 64 | SRAM-side write data |
| sram_rdata | input | 64 | SRAM-side read data, one cycle after a read |

## Verification
The assertions check, on every cycle:
- the single-cycle `done` pulse and the quick finish on a zero count;
- the frozen configuration while busy;
- the sticky error flag;
- the read-then-write pairing of beats;
- the 8-byte beat step and the per-side chunk stride;
- the rule that writes land only on the destination side.

Only the bench's scenarios can show that the right bytes reach the right addresses and that the check word has the XOR value. They also show that a corrupted stored check word is replaced rather than copied, and that a start issued mid-transfer leaves the write stream unchanged. For this, a scoreboard predicts each write from its own byte-level model.

// File: rtl/mcopy_pkg.sv
package mcopy_pkg;

  typedef enum logic [2:0] {
    ST_IDLE,
    ST_RD,
    ST_WR,
    ST_PRD,
    ST_PCHK,
    ST_PWR,
    ST_FIN
  } mc_state_t;

  // Lane fold: byte j of the result is the XOR of beat bytes j and j+4.
  function automatic logic [31:0] beat_fold(input logic [63:0] beat);
    return beat[31:0] ^ beat[63:32];
  endfunction

  // Byte distance between consecutive chunks on one side.
  function automatic int unsigned side_stride(input logic is_dram,
                                              input int unsigned data_b,
                                              input int unsigned chk_b);
    return is_dram ? data_b + chk_b : data_b;
  endfunction

endpackage

// File: rtl/mcopy_addr.sv
module mcopy_addr
  import mcopy_pkg::*;
#(
  parameter int AW          = 16,
  parameter int BEAT_BYTES  = 8,
  parameter int CHUNK_BYTES = 128,
  parameter int PAR_BYTES   = 4
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          load,
  input  logic [AW-1:0] src_i,
  input  logic [AW-1:0] dst_i,
  input  logic          src_dram,
  input  logic          dst_dram,
  input  logic          beat_adv,
  input  logic          chunk_adv,
  output logic [AW-1:0] s_addr,
  output logic [AW-1:0] d_addr,
  output logic [AW-1:0] s_par_addr,
  output logic [AW-1:0] d_par_addr,
  output logic          beat_last
);
  localparam int BEATS = CHUNK_BYTES / BEAT_BYTES;
  localparam int BCW   = $clog2(BEATS);

  logic [BCW-1:0] beat_q;
  logic [AW-1:0]  s_base_q, d_base_q;
  logic [AW-1:0]  beat_off, s_stride, d_stride;

  assign beat_off   = AW'(beat_q) * AW'(BEAT_BYTES);
  assign s_stride   = AW'(side_stride(src_dram, CHUNK_BYTES, PAR_BYTES));
  assign d_stride   = AW'(side_stride(dst_dram, CHUNK_BYTES, PAR_BYTES));
  assign s_addr     = s_base_q + beat_off;
  assign d_addr     = d_base_q + beat_off;
  assign s_par_addr = s_base_q + AW'(CHUNK_BYTES);
  assign d_par_addr = d_base_q + AW'(CHUNK_BYTES);
  assign beat_last  = (beat_q == BCW'(BEATS - 1));

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      beat_q   <= '0;
      s_base_q <= '0;
      d_base_q <= '0;
    end else if (load) begin
      beat_q   <= '0;
      s_base_q <= src_i;
      d_base_q <= dst_i;
    end else if (chunk_adv) begin
      beat_q   <= '0;
      s_base_q <= s_base_q + s_stride;
      d_base_q <= d_base_q + d_stride;
    end else if (beat_adv) begin
      beat_q <= beat_last ? '0 : beat_q + BCW'(1);
    end
  end

  // R3: within a chunk the source address steps by one beat
  p_beat_step_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (beat_adv && !beat_last && !chunk_adv && !load)
      |=> (s_addr == $past(s_addr) + AW'(BEAT_BYTES)));

  // R1: the destination check-word slot moves by the side's chunk stride
  p_chunk_stride_r1: assert property (@(posedge clk) disable iff (!rst_n)
    (chunk_adv && !load)
      |=> (d_par_addr == $past(d_par_addr) + $past(d_stride)));

endmodule

// File: rtl/mcopy_parity.sv
module mcopy_parity
  import mcopy_pkg::*;
(
  input  logic        clk,
  input  logic        rst_n,
  input  logic        clr,
  input  logic        acc_en,
  input  logic [63:0] beat,
  input  logic        chk_en,
  input  logic [31:0] stored,
  output logic [31:0] par,
  output logic        mismatch
);
  logic [31:0] acc_q;

  always_ff @(posedge clk) begin
    if (!rst_n)      acc_q <= '0;
    else if (clr)    acc_q <= '0;
    else if (acc_en) acc_q <= acc_q ^ beat_fold(beat);
  end

  assign par      = acc_q;
  assign mismatch = chk_en && (stored != acc_q);

  // R4: each chunk's check word starts from an empty accumulator
  p_acc_clear_r4: assert property (@(posedge clk) disable iff (!rst_n)
    clr |=> (par == 32'h0));

endmodule

// File: rtl/mcopy_ctrl.sv
module mcopy_ctrl
  import mcopy_pkg::*;
#(
  parameter int LW = 8
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          start,
  input  logic          src_dram_i,
  input  logic          dst_dram_i,
  input  logic [LW-1:0] len_i,
  input  logic          beat_last,
  input  logic          mismatch,
  output logic          load,
  output logic          beat_adv,
  output logic          chunk_adv,
  output logic          acc_clr,
  output logic          rd_data,
  output logic          wr_data,
  output logic          rd_par,
  output logic          chk_par,
  output logic          wr_par,
  output logic          busy,
  output logic          done,
  output logic          err,
  output logic          src_dram_q,
  output logic          dst_dram_q
);
  mc_state_t     st_q, st_d;
  logic [LW-1:0] len_q, chunk_q;
  logic          last_chunk, chunk_end, accept;

  assign accept     = (st_q == ST_IDLE) && start;
  assign rd_data    = (st_q == ST_RD);
  assign wr_data    = (st_q == ST_WR);
  assign rd_par     = (st_q == ST_PRD);
  assign chk_par    = (st_q == ST_PCHK);
  assign wr_par     = (st_q == ST_PWR);
  assign busy       = (st_q != ST_IDLE);
  assign done       = (st_q == ST_FIN);
  assign last_chunk = (chunk_q == len_q - LW'(1));
  assign chunk_end  = (wr_data && beat_last && !src_dram_q && !dst_dram_q)
                    || (chk_par && !dst_dram_q) || wr_par;
  assign load       = accept;
  assign beat_adv   = wr_data;
  assign chunk_adv  = chunk_end && !last_chunk;
  assign acc_clr    = accept || chunk_adv;

  always_comb begin
    st_d = st_q;
    unique case (st_q)
      ST_IDLE: if (start) st_d = (len_i == '0) ? ST_FIN : ST_RD;
      ST_RD:   st_d = ST_WR;
      ST_WR: begin
        if (!beat_last)      st_d = ST_RD;
        else if (src_dram_q) st_d = ST_PRD;
        else if (dst_dram_q) st_d = ST_PWR;
        else                 st_d = last_chunk ? ST_FIN : ST_RD;
      end
      ST_PRD:  st_d = ST_PCHK;
      ST_PCHK: st_d = dst_dram_q ? ST_PWR : (last_chunk ? ST_FIN : ST_RD);
      ST_PWR:  st_d = last_chunk ? ST_FIN : ST_RD;
      ST_FIN:  st_d = ST_IDLE;
      default: st_d = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      st_q       <= ST_IDLE;
      len_q      <= '0;
      chunk_q    <= '0;
      err        <= 1'b0;
      src_dram_q <= 1'b0;
      dst_dram_q <= 1'b0;
    end else begin
      st_q <= st_d;
      if (accept) begin
        len_q      <= len_i;
        chunk_q    <= '0;
        err        <= 1'b0;
        src_dram_q <= src_dram_i;
        dst_dram_q <= dst_dram_i;
      end else begin
        if (chunk_adv) chunk_q <= chunk_q + LW'(1);
        if (mismatch)  err     <= 1'b1;
      end
    end
  end

  // R7: completion is a single-cycle pulse
  p_done_single_r7: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> !done);

  // R6: a zero count finishes in the next cycle
  p_zero_fast_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (start && !busy && (len_i == '0)) |=> done);

  // R8: a transfer in progress keeps its configuration
  p_cfg_hold_r8: assert property (@(posedge clk) disable iff (!rst_n)
    busy |=> ($stable(len_q) && $stable(src_dram_q) && $stable(dst_dram_q)));

  // R5: a mismatch sets the flag
  p_err_set_r5: assert property (@(posedge clk) disable iff (!rst_n)
    mismatch |=> err);

  // R5: the flag holds until a new accepted start
  p_err_keep_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (err && !load) |=> err);

  // R3: every beat read is followed by its write
  p_read_pairs_r3: assert property (@(posedge clk) disable iff (!rst_n)
    rd_data |=> wr_data);

endmodule

// File: rtl/mcopy_engine.sv
module mcopy_engine
  import mcopy_pkg::*;
#(
  parameter int AW          = 16,
  parameter int LW          = 8,
  parameter int BEAT_BYTES  = 8,
  parameter int CHUNK_BYTES = 128,
  parameter int PAR_BYTES   = 4
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          start,
  input  logic          src_is_dram,
  input  logic          dst_is_dram,
  input  logic [AW-1:0] src_addr,
  input  logic [AW-1:0] dst_addr,
  input  logic [LW-1:0] num_chunks,
  output logic          busy,
  output logic          done,
  output logic          parity_err,
  output logic          dram_req,
  output logic          dram_we,
  output logic          dram_par,
  output logic [AW-1:0] dram_addr,
  output logic [63:0]   dram_wdata,
  input  logic [63:0]   dram_rdata,
  output logic          sram_req,
  output logic          sram_we,
  output logic [AW-1:0] sram_addr,
  output logic [63:0]   sram_wdata,
  input  logic [63:0]   sram_rdata
);
  logic          load, beat_adv, chunk_adv, acc_clr;
  logic          rd_data, wr_data, rd_par, chk_par, wr_par;
  logic          src_dram_q, dst_dram_q, beat_last, mismatch;
  logic [AW-1:0] s_addr, d_addr, s_par_addr, d_par_addr;
  logic [31:0]   par_word;
  logic [63:0]   src_rdata;
  logic          rd_any, wr_any;

  mcopy_ctrl #(.LW(LW)) u_ctrl (
    .clk(clk), .rst_n(rst_n), .start(start),
    .src_dram_i(src_is_dram), .dst_dram_i(dst_is_dram), .len_i(num_chunks),
    .beat_last(beat_last), .mismatch(mismatch),
    .load(load), .beat_adv(beat_adv), .chunk_adv(chunk_adv), .acc_clr(acc_clr),
    .rd_data(rd_data), .wr_data(wr_data), .rd_par(rd_par), .chk_par(chk_par),
    .wr_par(wr_par), .busy(busy), .done(done), .err(parity_err),
    .src_dram_q(src_dram_q), .dst_dram_q(dst_dram_q)
  );

  mcopy_addr #(
    .AW(AW), .BEAT_BYTES(BEAT_BYTES), .CHUNK_BYTES(CHUNK_BYTES), .PAR_BYTES(PAR_BYTES)
  ) u_addr (
    .clk(clk), .rst_n(rst_n), .load(load), .src_i(src_addr), .dst_i(dst_addr),
    .src_dram(src_dram_q), .dst_dram(dst_dram_q),
    .beat_adv(beat_adv), .chunk_adv(chunk_adv),
    .s_addr(s_addr), .d_addr(d_addr), .s_par_addr(s_par_addr),
    .d_par_addr(d_par_addr), .beat_last(beat_last)
  );

  mcopy_parity u_par (
    .clk(clk), .rst_n(rst_n), .clr(acc_clr), .acc_en(wr_data), .beat(src_rdata),
    .chk_en(chk_par), .stored(dram_rdata[31:0]), .par(par_word), .mismatch(mismatch)
  );

  assign src_rdata = src_dram_q ? dram_rdata : sram_rdata;
  assign rd_any    = rd_data || rd_par;
  assign wr_any    = wr_data || wr_par;

  assign dram_req   = (rd_any && src_dram_q) || (wr_any && dst_dram_q);
  assign dram_we    = wr_any && dst_dram_q;
  assign dram_par   = (rd_par && src_dram_q) || (wr_par && dst_dram_q);
  assign dram_addr  = dram_we ? (wr_par ? d_par_addr : d_addr)
                              : (rd_par ? s_par_addr : s_addr);
  assign dram_wdata = wr_par ? {32'h0, par_word} : src_rdata;

  assign sram_req   = (rd_data && !src_dram_q) || (wr_data && !dst_dram_q);
  assign sram_we    = wr_data && !dst_dram_q;
  assign sram_addr  = sram_we ? d_addr : s_addr;
  assign sram_wdata = src_rdata;

  // R9: writes reach only the destination side
  p_dram_wr_side_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (dram_req && dram_we) |-> dst_dram_q);

  p_sram_wr_side_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (sram_req && sram_we) |-> !dst_dram_q);

  // R9: no port activity while idle
  p_idle_quiet_r9: assert property (@(posedge clk) disable iff (!rst_n)
    !busy |-> (!dram_req && !sram_req));

endmodule

// File: tb/sim_mcopy_engine.sv
module sim_mcopy_engine;
  localparam int MSZ = 1024;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        start = 1'b0;
  logic        src_is_dram = 1'b0, dst_is_dram = 1'b0;
  logic [15:0] src_addr = '0, dst_addr = '0;
  logic [7:0]  num_chunks = '0;
  logic        busy, done, parity_err;
  logic        dram_req, dram_we, dram_par, sram_req, sram_we;
  logic [15:0] dram_addr, sram_addr;
  logic [63:0] dram_wdata, sram_wdata;
  logic [63:0] dram_rdata = '0, sram_rdata = '0;

  logic [7:0] dmem [MSZ];
  logic [7:0] smem [MSZ];

  int checks = 0;
  int errors = 0;

  typedef struct {
    bit          is_dram;
    int          addr;
    logic [63:0] data;
    bit          par;
    string       tag;
  } wr_item_t;

  wr_item_t exp_q[$];

  always #4 clk = ~clk;

  mcopy_engine u0 (
    .clk(clk), .rst_n(rst_n), .start(start),
    .src_is_dram(src_is_dram), .dst_is_dram(dst_is_dram),
    .src_addr(src_addr), .dst_addr(dst_addr), .num_chunks(num_chunks),
    .busy(busy), .done(done), .parity_err(parity_err),
    .dram_req(dram_req), .dram_we(dram_we), .dram_par(dram_par),
    .dram_addr(dram_addr), .dram_wdata(dram_wdata), .dram_rdata(dram_rdata),
    .sram_req(sram_req), .sram_we(sram_we), .sram_addr(sram_addr),
    .sram_wdata(sram_wdata), .sram_rdata(sram_rdata)
  );

  // Memory models: one-cycle read latency, byte addressed
  always @(posedge clk) begin
    if (dram_req) begin
      if (dram_we) begin
        for (int k = 0; k < (dram_par ? 4 : 8); k++)
          dmem[(int'(dram_addr) + k) % MSZ] = dram_wdata[8*k +: 8];
      end else begin
        for (int k = 0; k < 8; k++)
          dram_rdata[8*k +: 8] <= (dram_par && k >= 4) ? 8'h00
                                  : dmem[(int'(dram_addr) + k) % MSZ];
      end
    end
    if (sram_req) begin
      if (sram_we) begin
        for (int k = 0; k < 8; k++)
          smem[(int'(sram_addr) + k) % MSZ] = sram_wdata[8*k +: 8];
      end else begin
        for (int k = 0; k < 8; k++)
          sram_rdata[8*k +: 8] <= smem[(int'(sram_addr) + k) % MSZ];
      end
    end
  end

  function automatic logic [7:0] rd_byte(bit d, int a);
    return d ? dmem[a % MSZ] : smem[a % MSZ];
  endfunction

  task automatic check(bit ok, string tag, logic [63:0] act, logic [63:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s: actual %h expected %h", tag, act, exp);
    end
  endtask

  // Monitor: compare every write against the scoreboard
  task automatic take_write(bit d, logic [15:0] a, logic [63:0] w, bit p);
    wr_item_t it;
    logic [63:0] mask;
    if (exp_q.size() == 0) begin
      check(1'b0, "R8 R9 unexpected write", {48'h0, a}, 64'h0);
    end else begin
      it = exp_q.pop_front();
      mask = it.par ? 64'h0000_0000_FFFF_FFFF : '1;
      check((d == it.is_dram) && (int'(a) == it.addr) && (p == it.par)
            && ((w & mask) == (it.data & mask)),
            it.tag, {d, 15'h0, a, w[31:0]}, {it.is_dram, 15'h0, 16'(it.addr), it.data[31:0]});
    end
  endtask

  always @(negedge clk) begin
    if (rst_n) begin
      if (dram_req && dram_we) take_write(1'b1, dram_addr, dram_wdata, dram_par);
      if (sram_req && sram_we) take_write(1'b0, sram_addr, sram_wdata, 1'b0);
    end
  end

  // Builds a DRAM chunk with a correct check word
  task automatic fill_dram_chunk(int base, int seed);
    logic [7:0] cw [4];
    for (int j = 0; j < 4; j++) cw[j] = 8'h00;
    for (int i = 0; i < 128; i++) begin
      dmem[(base + i) % MSZ] = 8'(seed * 13 + i * 29 + (i >> 3));
      cw[i % 4] ^= dmem[(base + i) % MSZ];
    end
    for (int j = 0; j < 4; j++) dmem[(base + 128 + j) % MSZ] = cw[j];
  endtask

  // Driver: predict the writes, start the copy, wait for completion
  task automatic run_copy(int src, int dst, int len, bit sd, bit dd,
                          int poke, string tag);
    bit exp_err;
    int cycles;
    int n_done;
    exp_err = 1'b0;
    for (int c = 0; c < len; c++) begin
      int sb, db;
      logic [7:0] cw [4];
      sb = src + c * (sd ? 132 : 128);
      db = dst + c * (dd ? 132 : 128);
      for (int j = 0; j < 4; j++) cw[j] = 8'h00;
      for (int b = 0; b < 16; b++) begin
        wr_item_t it;
        it.is_dram = dd;
        it.addr = db + 8 * b;
        it.par = 1'b0;
        it.tag = {tag, " R1 R3 data beat"};
        for (int k = 0; k < 8; k++) begin
          it.data[8*k +: 8] = rd_byte(sd, sb + 8 * b + k);
          cw[(8 * b + k) % 4] ^= it.data[8*k +: 8];
        end
        exp_q.push_back(it);
      end
      if (sd) begin
        for (int j = 0; j < 4; j++)
          if (rd_byte(1'b1, sb + 128 + j) != cw[j]) exp_err = 1'b1;
      end
      if (dd) begin
        wr_item_t it;
        it.is_dram = 1'b1;
        it.addr = db + 128;
        it.par = 1'b1;
        it.tag = {tag, " R4 R1 check word"};
        it.data = {32'h0, cw[3], cw[2], cw[1], cw[0]};
        exp_q.push_back(it);
      end
    end
    src_addr = 16'(src);
    dst_addr = 16'(dst);
    num_chunks = 8'(len);
    src_is_dram = sd;
    dst_is_dram = dd;
    start = 1'b1;
    @(negedge clk);
    start = 1'b0;
    cycles = 1;
    n_done = 0;
    while (!done && cycles < 5000) begin
      if (cycles == poke) begin
        src_addr = 16'h0040;
        dst_addr = 16'h0100;
        num_chunks = 8'd3;
        src_is_dram = ~sd;
        dst_is_dram = ~dd;
        start = 1'b1;
      end
      @(negedge clk);
      start = 1'b0;
      cycles++;
    end
    check(done == 1'b1, {tag, " R7 done seen"}, {63'h0, done}, 64'h1);
    check(exp_q.size() == 0, {tag, " R7 all writes before done"},
          64'(exp_q.size()), 64'h0);
    check(parity_err == exp_err, {tag, " R5 error flag"}, {63'h0, parity_err}, {63'h0, exp_err});
    check(busy == 1'b1, {tag, " R7 busy in done cycle"}, {63'h0, busy}, 64'h1);
    @(negedge clk);
    check(done == 1'b0 && busy == 1'b0, {tag, " R7 single pulse"},
          {62'h0, done, busy}, 64'h0);
    for (int w = 0; w < 6; w++) begin
      @(negedge clk);
      if (done) n_done++;
    end
    check(n_done == 0, {tag, " R8 no extra completion"}, 64'(n_done), 64'h0);
    check(parity_err == exp_err, {tag, " R5 flag sticky after done"},
          {63'h0, parity_err}, {63'h0, exp_err});
    exp_q.delete();
  endtask

  initial begin : watchdog
    repeat (200000) @(posedge clk);
    errors++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin : main
    for (int i = 0; i < MSZ; i++) begin
      smem[i] = 8'(i * 7 + 3 + (i >> 5));
      dmem[i] = 8'h00;
    end
    fill_dram_chunk(660, 5);
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    check(!busy && !done && !parity_err, "R7 R5 reset state",
          {61'h0, busy, done, parity_err}, 64'h0);
    check(!dram_req && !sram_req, "R9 idle ports after reset",
          {62'h0, dram_req, sram_req}, 64'h0);

    // R2: SRAM side to DRAM side, two chunks
    run_copy(0, 0, 2, 1'b0, 1'b1, -1, "R2 sram->dram");
    // R2: DRAM side back to SRAM side, stored words are good
    run_copy(0, 512, 2, 1'b1, 1'b0, -1, "R2 dram->sram");
    // R4 R5: corrupt a stored word, DRAM to DRAM, fresh word expected
    dmem[130] = dmem[130] ^ 8'h5A;
    run_copy(0, 400, 1, 1'b1, 1'b1, -1, "R4 R5 dram->dram corrupt");
    // R5: next accepted start clears the flag
    run_copy(400, 768, 1, 1'b1, 1'b0, -1, "R5 clear on start");
    // R2: SRAM to SRAM
    run_copy(0, 256, 1, 1'b0, 1'b0, -1, "R2 sram->sram");
    // R5: independently built DRAM chunk copied to DRAM
    run_copy(660, 132, 1, 1'b1, 1'b1, -1, "R2 R5 built chunk dram->dram");
    // R8: start issued mid-transfer is ignored
    run_copy(128, 640, 1, 1'b0, 1'b0, 10, "R8 start while busy");

    // R6: zero chunk count
    src_addr = 16'h0;
    dst_addr = 16'h0;
    num_chunks = 8'd0;
    src_is_dram = 1'b0;
    dst_is_dram = 1'b1;
    start = 1'b1;
    @(negedge clk);
    start = 1'b0;
    check(done == 1'b1, "R6 zero length done next cycle", {63'h0, done}, 64'h1);
    check(!dram_req && !sram_req, "R6 zero length no access",
          {62'h0, dram_req, sram_req}, 64'h0);
    @(negedge clk);
    check(done == 1'b0 && busy == 1'b0, "R6 R7 zero length pulse ends",
          {62'h0, done, busy}, 64'h0);
    check(exp_q.size() == 0, "R6 zero length no writes", 64'(exp_q.size()), 64'h0);

    repeat (4) @(negedge clk);
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

endmodule